// File: doc/BRIEF.md
# Bus-Master DMA Channel Control Registers

This block is the host-facing register set for a single bus-master DMA channel. It holds a command register (start and direction), a status register (transfer active, error, interrupt) and a 32-bit base pointer to the descriptor table in memory. A simple register port carries single-cycle writes with a byte offset and an access size. The port also returns the selected register on a combinational read path.

The block drives one-cycle start and cancel strobes to a separate descriptor-walking engine. It hands that engine the current descriptor pointer and the transfer direction. The engine reports back with a done strobe and an error strobe. The device interrupt line is passed straight on to the host, and it also sets the interrupt flag in status.

Register select `sel_i`: 0 = command, 1 = status, 2 = table pointer, 3 = unused (reads zero, writes ignored). Access size `size_i`: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. Write data is taken from the low-order bytes of `wdata_i`. All register updates take effect at the clock edge on which `wr_en_i` is sampled high.

Top module: `dma_ctl_regs`

## Requirements
- R1: The command register stores only bit 0 (start) and bit 3 (direction); a command read returns all other bits as zero, and `dir_o` follows bit 3.
- R2: A command write whose bit 0 equals the stored start bit pulses neither `start_o` nor `cancel_o`. It leaves the active status bit and `cur_ptr_o` unchanged.
- R3: A command write that changes start from 1 to 0 pulses `cancel_o` high for one cycle after the write edge and clears the active bit (status bit 0).
- R4: A command write that changes start from 0 to 1 loads `cur_ptr_o` from the table pointer. If the active bit was clear, it also sets the active bit and pulses `start_o` for one cycle after the write edge.
- R5: A table pointer write replaces only the addressed bytes. For size 1, 2 or 4 bytes at byte offset `off_i`, byte k of `wdata_i` goes to byte `off_i`+k, and bytes beyond byte 3 are dropped.
- R6: Bits 1:0 of the stored table pointer are always zero, whatever data is written.
- R7: A table pointer read returns the pointer shifted right by 8×`off_i` bits and masked to the access size.
- R8: `host_irq_o` follows `dev_irq_i`. On a clock edge where `dev_irq_i` is high, status bit 2 becomes set, and a host clear does not win over it. A low `dev_irq_i` leaves status bit 2 unchanged.
- R9: Status bits 2 (interrupt) and 1 (error) are cleared by writing 1 to them, and writing 0 has no effect. `err_i` sets bit 1. Bit 0 (active) ignores status writes, and status bits 7:3 read zero.
- R10: A `done_i` strobe clears the active bit at the next edge, unless a command write on the same edge sets it.
- R11: While `rst_ni` is low, `cancel_o` is high and the command, status and table pointer registers and `cur_ptr_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| sel_i | input | 2 | Register select: 0 command, 1 status, 2 table pointer |
| size_i | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| off_i | input | 2 | Byte offset within the table pointer |
| wdata_i | input | 32 | Write data, low-order bytes first |
| rdata_o | output | 32 | Read data for the selected register |
| start_o | output | 1 | One-cycle start request to the engine |
| cancel_o | output | 1 | One-cycle cancel request; high during reset |
| done_i | input | 1 | Engine completion strobe |
| err_i | input | 1 | Engine error strobe |
| dir_o | output | 1 | Transfer direction (command bit 3) |
| cur_ptr_o | output | 32 | Current descriptor pointer for the engine |
| dev_irq_i | input | 1 | Device interrupt line |
| host_irq_o | output | 1 | Interrupt line forwarded to the host |

## Verification
The hardest case to reach is a command write that leaves the start bit unchanged while a transfer is active. It must produce no strobe and must not reload the current pointer. The stimulus starts a transfer and then moves the table pointer to a new value. It then rewrites the command with start still set and the direction bit changed, and checks that `cur_ptr_o` still holds the old base. A second start after a cancel confirms that the new base is picked up. The interrupt race, a host clear arriving while the device line is still high, is produced by holding `dev_irq_i` high across a write-one-to-clear.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_STAT = 2'd1,
    SEL_PTR  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int CMD_GO  = 0;
  localparam int CMD_DIR = 3;
  localparam int ST_ACT  = 0;
  localparam int ST_ERR  = 1;
  localparam int ST_INT  = 2;
endpackage

// File: rtl/dma_ptr_reg.sv
module dma_ptr_reg #(
  parameter int PTR_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [1:0]       size_i,
  input  logic [1:0]       off_i,
  input  logic [PTR_W-1:0] wdata_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic [PTR_W-1:0] rdata_o
);
  localparam int NB = PTR_W / 8;

  logic [NB-1:0]    be_raw;
  logic [NB-1:0]    be;
  logic [PTR_W-1:0] wsh;
  logic [PTR_W-1:0] rmask;
  logic [PTR_W-1:0] ptr_q;
  logic [4:0]       shamt;

  always_comb begin
    case (size_i)
      2'd0:    be_raw = NB'(1);
      2'd1:    be_raw = NB'(3);
      default: be_raw = '1;
    endcase
  end

  assign shamt = {off_i, 3'b000};
  assign be    = be_raw << off_i;
  assign wsh   = wdata_i << shamt;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign rmask[b*8 +: 8] = {8{be_raw[b]}};
    if (b == 0) begin : g_low
      // low two bits never stored
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            ptr_q[7:0] <= '0;
        else if (wr_i && be[0]) ptr_q[7:0] <= {wsh[7:2], 2'b00};
      end
    end else begin : g_hi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            ptr_q[b*8 +: 8] <= '0;
        else if (wr_i && be[b]) ptr_q[b*8 +: 8] <= wsh[b*8 +: 8];
      end
    end
  end

  assign ptr_o   = ptr_q;
  assign rdata_o = (ptr_q >> shamt) & rmask;
endmodule

// File: rtl/dma_cmd_ctl.sv
module dma_cmd_ctl
  import dma_regs_pkg::*;
#(
  parameter int PTR_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [7:0]       wdata_i,
  input  logic [PTR_W-1:0] base_i,
  input  logic             done_i,
  output logic [7:0]       cmd_o,
  output logic             active_o,
  output logic             start_o,
  output logic             cancel_o,
  output logic [PTR_W-1:0] cur_ptr_o
);
  logic             go_q, dir_q, act_q, start_q, cancel_q;
  logic [PTR_W-1:0] cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      go_q     <= 1'b0;
      dir_q    <= 1'b0;
      act_q    <= 1'b0;
      start_q  <= 1'b0;
      cancel_q <= 1'b0;
      cur_q    <= '0;
    end else begin
      start_q  <= 1'b0;
      cancel_q <= 1'b0;
      if (done_i) act_q <= 1'b0;
      if (wr_i) begin
        // only an edge on the start bit acts
        if (wdata_i[CMD_GO] != go_q) begin
          if (!wdata_i[CMD_GO]) begin
            cancel_q <= 1'b1;
            act_q    <= 1'b0;
          end else begin
            cur_q <= base_i;
            if (!act_q) begin
              act_q   <= 1'b1;
              start_q <= 1'b1;
            end
          end
        end
        go_q  <= wdata_i[CMD_GO];
        dir_q <= wdata_i[CMD_DIR];
      end
    end
  end

  always_comb begin
    cmd_o          = '0;
    cmd_o[CMD_GO]  = go_q;
    cmd_o[CMD_DIR] = dir_q;
  end

  assign active_o  = act_q;
  assign start_o   = start_q;
  assign cancel_o  = cancel_q | ~rst_ni;
  assign cur_ptr_o = cur_q;
endmodule

// File: rtl/dma_stat_reg.sv
module dma_stat_reg
  import dma_regs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       active_i,
  input  logic       err_i,
  input  logic       irq_i,
  output logic [7:0] status_o
);
  logic int_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      // set beats write-one-to-clear
      if (irq_i)                        int_q <= 1'b1;
      else if (wr_i && wdata_i[ST_INT]) int_q <= 1'b0;
      if (err_i)                        err_q <= 1'b1;
      else if (wr_i && wdata_i[ST_ERR]) err_q <= 1'b0;
    end
  end

  always_comb begin
    status_o         = '0;
    status_o[ST_ACT] = active_i;
    status_o[ST_ERR] = err_q;
    status_o[ST_INT] = int_q;
  end
endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
  import dma_regs_pkg::*;
#(
  parameter int PTR_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       sel_i,
  input  logic [1:0]       size_i,
  input  logic [1:0]       off_i,
  input  logic [PTR_W-1:0] wdata_i,
  output logic [PTR_W-1:0] rdata_o,
  output logic             start_o,
  output logic             cancel_o,
  input  logic             done_i,
  input  logic             err_i,
  output logic             dir_o,
  output logic [PTR_W-1:0] cur_ptr_o,
  input  logic             dev_irq_i,
  output logic             host_irq_o
);
  reg_sel_e         sel;
  logic             wr_cmd, wr_stat, wr_ptr, act_w;
  logic [7:0]       cmd_w, stat_w;
  logic [PTR_W-1:0] base_w, ptr_rd;

  assign sel     = reg_sel_e'(sel_i);
  assign wr_cmd  = wr_en_i && (sel == SEL_CMD);
  assign wr_stat = wr_en_i && (sel == SEL_STAT);
  assign wr_ptr  = wr_en_i && (sel == SEL_PTR);

  dma_ptr_reg #(.PTR_W(PTR_W)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_ptr),
    .size_i  (size_i),
    .off_i   (off_i),
    .wdata_i (wdata_i),
    .ptr_o   (base_w),
    .rdata_o (ptr_rd)
  );

  dma_cmd_ctl #(.PTR_W(PTR_W)) u_cmd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_cmd),
    .wdata_i   (wdata_i[7:0]),
    .base_i    (base_w),
    .done_i    (done_i),
    .cmd_o     (cmd_w),
    .active_o  (act_w),
    .start_o   (start_o),
    .cancel_o  (cancel_o),
    .cur_ptr_o (cur_ptr_o)
  );

  dma_stat_reg u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_stat),
    .wdata_i  (wdata_i[7:0]),
    .active_i (act_w),
    .err_i    (err_i),
    .irq_i    (dev_irq_i),
    .status_o (stat_w)
  );

  always_comb begin
    case (sel)
      SEL_CMD:  rdata_o = PTR_W'(cmd_w);
      SEL_STAT: rdata_o = PTR_W'(stat_w);
      SEL_PTR:  rdata_o = ptr_rd;
      default:  rdata_o = '0;
    endcase
  end

  assign dir_o      = cmd_w[CMD_DIR];
  assign host_irq_o = dev_irq_i;
endmodule

// File: rtl/dma_ctl_regs_chk.sv
module dma_ctl_regs_chk #(
  parameter int PTR_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [1:0]       sel_i,
  input logic [1:0]       off_i,
  input logic [PTR_W-1:0] wdata_i,
  input logic [PTR_W-1:0] rdata_o,
  input logic             start_o,
  input logic             cancel_o,
  input logic             done_i,
  input logic [7:0]       cmd_w,
  input logic [7:0]       stat_w,
  input logic [PTR_W-1:0] base_w,
  input logic [PTR_W-1:0] cur_ptr_o,
  input logic             dev_irq_i
);
  logic wr_c, wr_s;
  assign wr_c = wr_en_i && (sel_i == 2'd0);
  assign wr_s = wr_en_i && (sel_i == 2'd1);

  p_cmd_rd_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 2'd0) |-> ((rdata_o & 32'hFFFF_FFF6) == 32'h0));

  p_same_go_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_c && (wdata_i[0] == cmd_w[0])) |=> (!start_o && !cancel_o));

  p_cancel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_c && cmd_w[0] && !wdata_i[0]) |=> (cancel_o && !stat_w[0]));

  p_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_c && !cmd_w[0] && wdata_i[0] && !stat_w[0])
      |=> (start_o && stat_w[0] && (cur_ptr_o == $past(base_w))));

  p_ptr_align_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sel_i == 2'd2) && (off_i == 2'd0)) |-> (rdata_o[1:0] == 2'b00));

  p_irq_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_irq_i |=> stat_w[2]);

  p_irq_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dev_irq_i && !wr_s) |=> (stat_w[2] == $past(stat_w[2])));

  p_act_ro_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_s && !done_i) |=> (stat_w[0] == $past(stat_w[0])));

  p_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !wr_c) |=> !stat_w[0]);

  p_strobe_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_o, cancel_o}));
endmodule

bind dma_ctl_regs dma_ctl_regs_chk #(.PTR_W(PTR_W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .sel_i     (sel_i),
  .off_i     (off_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .start_o   (start_o),
  .cancel_o  (cancel_o),
  .done_i    (done_i),
  .cmd_w     (cmd_w),
  .stat_w    (stat_w),
  .base_w    (base_w),
  .cur_ptr_o (cur_ptr_o),
  .dev_irq_i (dev_irq_i)
);

// File: tb/dma_ctl_regs_tb_top.sv
module dma_ctl_regs_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  sel_i = 2'd0, size_i = 2'd0, off_i = 2'd0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o, cur_ptr_o;
  logic        start_o, cancel_o, dir_o, host_irq_o;
  logic        done_i = 1'b0, err_i = 1'b0, dev_irq_i = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;

  dma_ctl_regs dut_i (
    .clk_i, .rst_ni, .wr_en_i, .sel_i, .size_i, .off_i, .wdata_i,
    .rdata_o, .start_o, .cancel_o, .done_i, .err_i, .dir_o,
    .cur_ptr_o, .dev_irq_i, .host_irq_o
  );

  // {size, off, wdata, expected full pointer}
  localparam logic [67:0] VEC [0:5] = '{
    {2'd2, 2'd0, 32'h1234_5677, 32'h1234_5674},
    {2'd0, 2'd1, 32'h0000_00AB, 32'h1234_AB74},
    {2'd1, 2'd2, 32'h0000_BEEF, 32'hBEEF_AB74},
    {2'd0, 2'd0, 32'h0000_00FF, 32'hBEEF_ABFC},
    {2'd1, 2'd0, 32'h0000_0003, 32'hBEEF_0000},
    {2'd0, 2'd3, 32'h0000_005A, 32'h5AEF_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [1:0] sz, input logic [1:0] o,
                    input logic [31:0] d);
    sel_i = s; size_i = sz; off_i = o; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, input logic [1:0] sz, input logic [1:0] o,
                    output logic [31:0] d);
    sel_i = s; size_i = sz; off_i = o;
    #1 d = rdata_o;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    #5 check("R11 cancel in reset", {31'b0, cancel_o}, 32'h1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd(2'd0, 2'd2, 2'd0, r); check("R11 cmd reset", r, 32'h0);
    rd(2'd1, 2'd2, 2'd0, r); check("R11 status reset", r, 32'h0);
    rd(2'd2, 2'd2, 2'd0, r); check("R11 ptr reset", r, 32'h0);
    check("R11 strobes idle", {30'b0, start_o, cancel_o}, 32'h0);

    // R5 R6 byte-enabled pointer writes
    foreach (VEC[i]) begin
      wr(2'd2, VEC[i][67:66], VEC[i][65:64], VEC[i][63:32]);
      rd(2'd2, 2'd2, 2'd0, r);
      check($sformatf("R5 R6 ptr vector %0d", i), r, VEC[i][31:0]);
    end

    // R7 partial reads of 0x5AEF0000
    rd(2'd2, 2'd0, 2'd3, r); check("R7 byte read off3", r, 32'h5A);
    rd(2'd2, 2'd1, 2'd1, r); check("R7 half read off1", r, 32'hEF00);
    rd(2'd2, 2'd1, 2'd2, r); check("R7 half read off2", r, 32'h5AEF);
    rd(2'd3, 2'd2, 2'd0, r); check("R7 unused select", r, 32'h0);

    // R1 only bits 0 and 3 kept; start stays 0 so R2 no strobe
    wr(2'd2, 2'd2, 2'd0, 32'h0000_1000);
    wr(2'd0, 2'd0, 2'd0, 32'h0000_00FE);
    check("R2 no strobe", {30'b0, start_o, cancel_o}, 32'h0);
    rd(2'd0, 2'd2, 2'd0, r); check("R1 cmd readback", r, 32'h08);
    check("R1 dir_o", {31'b0, dir_o}, 32'h1);

    // R4 start
    wr(2'd0, 2'd0, 2'd0, 32'h0000_0001);
    check("R4 start pulse", {30'b0, start_o, cancel_o}, 32'h2);
    check("R4 cur_ptr load", cur_ptr_o, 32'h0000_1000);
    rd(2'd1, 2'd2, 2'd0, r); check("R4 active set", r, 32'h01);
    @(negedge clk_i);
    check("R4 start one cycle", {31'b0, start_o}, 32'h0);

    // R2 rewrite with start unchanged after base moved
    wr(2'd2, 2'd2, 2'd0, 32'h0000_2000);
    wr(2'd0, 2'd0, 2'd0, 32'h0000_0009);
    check("R2 no strobe while active", {30'b0, start_o, cancel_o}, 32'h0);
    check("R2 cur_ptr kept", cur_ptr_o, 32'h0000_1000);
    rd(2'd1, 2'd2, 2'd0, r); check("R2 active kept", r, 32'h01);

    // R10 done
    done_i = 1'b1; @(negedge clk_i); done_i = 1'b0;
    rd(2'd1, 2'd2, 2'd0, r); check("R10 done clears active", r, 32'h00);
    rd(2'd0, 2'd2, 2'd0, r); check("R10 cmd untouched", r, 32'h09);

    // R3 cancel of an active transfer
    wr(2'd0, 2'd0, 2'd0, 32'h0000_0000);
    check("R3 cancel after done", {30'b0, start_o, cancel_o}, 32'h1);
    wr(2'd0, 2'd0, 2'd0, 32'h0000_0001);
    check("R4 cur_ptr new base", cur_ptr_o, 32'h0000_2000);
    wr(2'd0, 2'd0, 2'd0, 32'h0000_0000);
    check("R3 cancel pulse", {30'b0, start_o, cancel_o}, 32'h1);
    rd(2'd1, 2'd2, 2'd0, r); check("R3 active cleared", r, 32'h00);
    @(negedge clk_i);
    check("R3 cancel one cycle", {31'b0, cancel_o}, 32'h0);

    // R8 interrupt merge
    dev_irq_i = 1'b1; #1;
    check("R8 forward high", {31'b0, host_irq_o}, 32'h1);
    @(negedge clk_i);
    rd(2'd1, 2'd2, 2'd0, r); check("R8 int set", r, 32'h04);
    dev_irq_i = 1'b0; #1;
    check("R8 forward low", {31'b0, host_irq_o}, 32'h0);
    @(negedge clk_i);
    rd(2'd1, 2'd2, 2'd0, r); check("R8 low keeps int", r, 32'h04);

    // R9 write-one-to-clear
    err_i = 1'b1; @(negedge clk_i); err_i = 1'b0;
    rd(2'd1, 2'd2, 2'd0, r); check("R9 err set", r, 32'h06);
    wr(2'd1, 2'd0, 2'd0, 32'h0000_00F9);
    rd(2'd1, 2'd2, 2'd0, r); check("R9 bit0 and high bits ignored", r, 32'h06);
    wr(2'd1, 2'd0, 2'd0, 32'h0000_0004);
    rd(2'd1, 2'd2, 2'd0, r); check("R9 clear int", r, 32'h02);
    wr(2'd1, 2'd0, 2'd0, 32'h0000_0002);
    rd(2'd1, 2'd2, 2'd0, r); check("R9 clear err", r, 32'h00);

    // R8 set wins over clear
    dev_irq_i = 1'b1;
    wr(2'd1, 2'd0, 2'd0, 32'h0000_0004);
    rd(2'd1, 2'd2, 2'd0, r); check("R8 set beats clear", r, 32'h04);
    dev_irq_i = 1'b0;
    wr(2'd1, 2'd0, 2'd0, 32'h0000_0004);
    rd(2'd1, 2'd2, 2'd0, r); check("R9 clear after low", r, 32'h00);

    // R11 reset with a transfer active
    wr(2'd0, 2'd0, 2'd0, 32'h0000_0009);
    rst_ni = 1'b0; #1;
    check("R11 cancel during reset", {31'b0, cancel_o}, 32'h1);
    check("R11 cur_ptr cleared", cur_ptr_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd(2'd0, 2'd2, 2'd0, r); check("R11 cmd cleared", r, 32'h0);
    rd(2'd1, 2'd2, 2'd0, r); check("R11 status cleared", r, 32'h0);
    rd(2'd2, 2'd2, 2'd0, r); check("R11 ptr cleared", r, 32'h0);

    finish_run();
  end
endmodule